// File: doc/BRIEF.md
# Word FIFO Control and Interrupt Status Unit

This unit sits beside a pair of word FIFOs, one for transmit and one for receive, and gives software a small register view of them. It holds a control register with two flush commands and two trigger levels, reflects the live FIFO occupancy counts, and keeps an eight-bit event status register with a matching enable mask. A single interrupt line is raised whenever an enabled status bit is set. The FIFO memories and the serial bus engine are outside this unit: occupancy counts, push and pop strobes and the bus events come in as inputs, and flush requests go out as outputs.

Software reaches four registers through a simple word port with a one-cycle registered read. The register select values are 0 for FIFO control, 1 for FIFO status, 2 for the interrupt enable mask and 3 for the interrupt status. The receive and transmit data-request bits are driven by comparing the occupancy counts against the programmed trigger levels. Overflow and underflow are detected on the push and pop strobes.

Top module: `qfc_unit`

## Requirements
- R1: After a synchronous reset, the control register, mask register and status register all read 0, `irq` is 0 and both flush requests are 0. A read issued with `reg_rd` high at a clock edge returns its value on `reg_rdata` after that edge. Select 0 is control, 1 is FIFO status, 2 is mask and 3 is status.
- R2: Writing control with bit 1 set starts a transmit flush, and bit 0 set starts a receive flush. A started flush reads back as 1 in that bit and drives its request output high until the matching done input is seen. It then clears by itself. Writing 0 to the bit does not cancel it.
- R3: The control register holds a 3-bit transmit trigger level in bits 7:5 and a 3-bit receive trigger level in bits 4:2. Both read back as written.
- R4: The FIFO status register reads the transmit free-slot count in bits 7:4 and the receive filled-word count in bits 3:0.
- R5: Status bit 0, receive data request, is set on every cycle in which the receive filled count is greater than the receive trigger level.
- R6: Status bit 1, transmit data request, is set on every cycle in which the transmit free count is at least the transmit trigger level plus one.
- R7: A push while the transmit free count is 0 sets status bit 5 (overflow) and is dropped: `tx_accept` stays low. Otherwise `tx_accept` follows `tx_push`.
- R8: A pop while the receive filled count is 0 sets status bit 4 (underflow) and loads 0 into `rx_word`. Otherwise a pop loads `rx_mem_data` into `rx_word`.
- R9: The event inputs set status bits as follows: packet done sets bit 7, all packets done sets bit 6, no acknowledge sets bit 3, and arbitration lost sets bit 2.
- R10: Writing the status register clears exactly the bits written as 1, so 0xFF clears all of them. If a bit is set and cleared in the same cycle, it ends up set.
- R11: The mask uses the status bit positions, with 1 enabling a source. `irq` is the registered OR of status AND mask, so it follows the status and mask one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tx_free | input | 4 | Transmit FIFO free word slots |
| rx_fill | input | 4 | Receive FIFO filled words |
| tx_push | input | 1 | Push request into transmit FIFO |
| tx_accept | output | 1 | Push allowed to reach the FIFO |
| rx_pop | input | 1 | Pop request from receive FIFO |
| rx_mem_data | input | 32 | Word at the head of the receive FIFO |
| rx_word | output | 32 | Last popped word, 0 on underflow |
| tx_flush_req | output | 1 | Transmit flush in progress |
| rx_flush_req | output | 1 | Receive flush in progress |
| tx_flush_done | input | 1 | Transmit flush finished |
| rx_flush_done | input | 1 | Receive flush finished |
| ev_pkt_done | input | 1 | Packet finished event |
| ev_all_done | input | 1 | All packets finished event |
| ev_nack | input | 1 | No acknowledge event |
| ev_arb_lost | input | 1 | Arbitration lost event |
| irq | output | 1 | Interrupt request |

## Verification
The two data-request comparisons are swept over every trigger level, 0 to 7, against every occupancy count, 0 to 15. This separates a strict from a non-strict compare and shows any off-by-one at the trigger boundary. Push and pop are each tried at an empty or full count and at a non-zero count, which tells dropped or zeroed transfers apart from normal ones. Set-versus-clear collisions, selective clearing, mask gating of the interrupt and the lifetime of a flush request are each driven as short directed sequences.

// File: rtl/qfc_pkg.sv
package qfc_pkg;
  localparam int EV_W        = 8;
  localparam int TRIG_W      = 3;
  localparam int TX_TRIG_LSB = 5;
  localparam int RX_TRIG_LSB = 2;
  localparam int TX_FLUSH_B  = 1;
  localparam int RX_FLUSH_B  = 0;

  localparam int B_PKT   = 7;
  localparam int B_ALL   = 6;
  localparam int B_OVF   = 5;
  localparam int B_UNF   = 4;
  localparam int B_NACK  = 3;
  localparam int B_ARB   = 2;
  localparam int B_TXREQ = 1;
  localparam int B_RXREQ = 0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_FSTA = 2'd1,
    SEL_MASK = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/qfc_flush.sv
module qfc_flush (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)        pend <= 1'b0;
    else if (start) pend <= 1'b1;
    else if (done)  pend <= 1'b0;
  end
endmodule

// File: rtl/qfc_level.sv
module qfc_level #(
  parameter int CNT_W  = 4,
  parameter int TRIG_W = 3
) (
  input  logic [CNT_W-1:0]  tx_free,
  input  logic [CNT_W-1:0]  rx_fill,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [TRIG_W-1:0] rx_trig,
  output logic              tx_req,
  output logic              rx_req
);
  localparam int CMP_W = CNT_W + TRIG_W + 1;

  logic [CMP_W-1:0] free_x, fill_x, txt_x, rxt_x;

  always_comb begin
    free_x = CMP_W'(tx_free);
    fill_x = CMP_W'(rx_fill);
    txt_x  = CMP_W'(tx_trig);
    rxt_x  = CMP_W'(rx_trig);
    rx_req = fill_x > rxt_x;
    tx_req = free_x >= (txt_x + CMP_W'(1));
  end
endmodule

// File: rtl/qfc_evstat.sv
module qfc_evstat #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             stat[i] <= 1'b0;
      else if (set_vec[i]) stat[i] <= 1'b1;
      else if (clr_vec[i]) stat[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/qfc_unit.sv
module qfc_unit
  import qfc_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [CNT_W-1:0]  tx_free,
  input  logic [CNT_W-1:0]  rx_fill,
  input  logic              tx_push,
  output logic              tx_accept,
  input  logic              rx_pop,
  input  logic [DATA_W-1:0] rx_mem_data,
  output logic [DATA_W-1:0] rx_word,
  output logic              tx_flush_req,
  output logic              rx_flush_req,
  input  logic              tx_flush_done,
  input  logic              rx_flush_done,
  input  logic              ev_pkt_done,
  input  logic              ev_all_done,
  input  logic              ev_nack,
  input  logic              ev_arb_lost,
  output logic              irq
);
  localparam int REG_W = 8;
  localparam int HALF  = REG_W / 2;

  logic [TRIG_W-1:0] tx_trig_q, rx_trig_q;
  logic [EV_W-1:0]   mask_q, stat_q, set_vec, clr_vec;
  logic              wr_ctrl, wr_mask, wr_stat;
  logic              tx_req, rx_req, tx_empty_slot, rx_empty;
  logic [1:0]        flush_start, flush_done, flush_pend;

  assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
  assign wr_mask = reg_wr && (reg_addr == SEL_MASK);
  assign wr_stat = reg_wr && (reg_addr == SEL_STAT);

  assign tx_empty_slot = (tx_free == '0);
  assign rx_empty      = (rx_fill == '0);
  assign tx_accept     = tx_push && !tx_empty_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_trig_q <= '0;
      rx_trig_q <= '0;
    end else if (wr_ctrl) begin
      tx_trig_q <= reg_wdata[TX_TRIG_LSB +: TRIG_W];
      rx_trig_q <= reg_wdata[RX_TRIG_LSB +: TRIG_W];
    end
  end

  assign flush_start[0] = wr_ctrl && reg_wdata[RX_FLUSH_B];
  assign flush_start[1] = wr_ctrl && reg_wdata[TX_FLUSH_B];
  assign flush_done     = {tx_flush_done, rx_flush_done};

  for (genvar d = 0; d < 2; d++) begin : g_flush
    qfc_flush u_flush (
      .clk   (clk),
      .rst   (rst),
      .start (flush_start[d]),
      .done  (flush_done[d]),
      .pend  (flush_pend[d])
    );
  end

  assign rx_flush_req = flush_pend[0];
  assign tx_flush_req = flush_pend[1];

  qfc_level #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_level (
    .tx_free (tx_free),
    .rx_fill (rx_fill),
    .tx_trig (tx_trig_q),
    .rx_trig (rx_trig_q),
    .tx_req  (tx_req),
    .rx_req  (rx_req)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_PKT]   = ev_pkt_done;
    set_vec[B_ALL]   = ev_all_done;
    set_vec[B_OVF]   = tx_push && tx_empty_slot;
    set_vec[B_UNF]   = rx_pop && rx_empty;
    set_vec[B_NACK]  = ev_nack;
    set_vec[B_ARB]   = ev_arb_lost;
    set_vec[B_TXREQ] = tx_req;
    set_vec[B_RXREQ] = rx_req;
    clr_vec          = wr_stat ? reg_wdata[EV_W-1:0] : '0;
  end

  qfc_evstat #(.N(EV_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat    (stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[EV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_q & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         rx_word <= '0;
    else if (rx_pop) rx_word <= rx_empty ? '0 : rx_mem_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        SEL_CTRL: begin
          reg_rdata                              <= '0;
          reg_rdata[TX_TRIG_LSB +: TRIG_W]       <= tx_trig_q;
          reg_rdata[RX_TRIG_LSB +: TRIG_W]       <= rx_trig_q;
          reg_rdata[TX_FLUSH_B]                  <= flush_pend[1];
          reg_rdata[RX_FLUSH_B]                  <= flush_pend[0];
        end
        SEL_FSTA: reg_rdata <= {HALF'(tx_free), HALF'(rx_fill)};
        SEL_MASK: reg_rdata <= REG_W'(mask_q);
        default:  reg_rdata <= REG_W'(stat_q);
      endcase
    end
  end
endmodule

// File: rtl/qfc_unit_chk.sv
module qfc_unit_chk
  import qfc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [CNT_W-1:0]  tx_free,
  input logic [CNT_W-1:0]  rx_fill,
  input logic              tx_push,
  input logic              tx_accept,
  input logic              rx_pop,
  input logic              tx_flush_req,
  input logic              tx_flush_done,
  input logic [EV_W-1:0]   stat_q,
  input logic [EV_W-1:0]   mask_q,
  input logic [TRIG_W-1:0] rx_trig_q,
  input logic              irq
);
  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & mask_q) != '0) |=> irq);

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && !$past(rst)) |-> ($past(stat_q & mask_q) != '0));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_free == '0) |-> (!tx_accept ##1 stat_q[B_OVF]));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_fill == '0) |=> stat_q[B_UNF]);

  assert_flush_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_flush_req && tx_flush_done &&
     !(reg_wr && reg_addr == SEL_CTRL && reg_wdata[TX_FLUSH_B])) |=> !tx_flush_req);

  assert_flush_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_flush_req && !tx_flush_done) |=> tx_flush_req);

  assert_rx_request_R5: assert property (@(posedge clk) disable iff (rst)
    (CNT_W'(rx_fill) > CNT_W'(rx_trig_q)) |=> stat_q[B_RXREQ]);
endmodule

bind qfc_unit qfc_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .tx_free       (tx_free),
  .rx_fill       (rx_fill),
  .tx_push       (tx_push),
  .tx_accept     (tx_accept),
  .rx_pop        (rx_pop),
  .tx_flush_req  (tx_flush_req),
  .tx_flush_done (tx_flush_done),
  .stat_q        (stat_q),
  .mask_q        (mask_q),
  .rx_trig_q     (rx_trig_q),
  .irq           (irq)
);

// File: tb/tb_qfc_unit.sv
`timescale 1ns/1ps
module tb_qfc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [3:0]  tx_free, rx_fill;
  logic        tx_push, tx_accept, rx_pop;
  logic [31:0] rx_mem_data, rx_word;
  logic        tx_flush_req, rx_flush_req, tx_flush_done, rx_flush_done;
  logic        ev_pkt_done, ev_all_done, ev_nack, ev_arb_lost, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  qfc_unit dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    tx_free = 0; rx_fill = 0; tx_push = 0; rx_pop = 0; rx_mem_data = 0;
    tx_flush_done = 0; rx_flush_done = 0;
    ev_pkt_done = 0; ev_all_done = 0; ev_nack = 0; ev_arb_lost = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd2, d); check("R1 mask", d, 0);
    rd(2'd3, d); check("R1 status", d, 0);
    check("R1 irq", irq, 0);
    check("R1 flush reqs", {tx_flush_req, rx_flush_req}, 0);

    // R3 trigger readback
    wr(2'd0, 8'b101_011_00); rd(2'd0, d); check("R3 trig readback", d, 8'hAC);
    wr(2'd0, 8'b010_110_00); rd(2'd0, d); check("R3 trig readback", d, 8'h58);

    // R4 fifo status sweep
    for (int f = 0; f < 16; f++) begin
      tx_free = 4'(f); rx_fill = 4'(15 - f);
      rd(2'd1, d); check("R4 fifo status", d, {4'(f), 4'(15 - f)});
    end

    // R5 receive request sweep
    tx_free = 0;
    for (int t = 0; t < 8; t++) begin
      for (int f = 0; f < 16; f++) begin
        rx_fill = 0;
        wr(2'd0, {3'd0, 3'(t), 2'b00});
        wr(2'd3, 8'hFF);
        rx_fill = 4'(f);
        step();
        rd(2'd3, d);
        check("R5 rx request", d, {7'd0, (f > t)});
      end
    end

    // R6 transmit request sweep
    rx_fill = 0;
    for (int t = 0; t < 8; t++) begin
      for (int f = 0; f < 16; f++) begin
        tx_free = 0;
        wr(2'd0, {3'(t), 3'd7, 2'b00});
        wr(2'd3, 8'hFF);
        tx_free = 4'(f);
        step();
        rd(2'd3, d);
        check("R6 tx request", d, {6'd0, (f >= t + 1), 1'b0});
      end
    end

    // R7 overflow
    wr(2'd0, {3'd7, 3'd7, 2'b00});
    tx_free = 0; rx_fill = 0; wr(2'd3, 8'hFF);
    tx_push = 1; #1 check("R7 dropped push", tx_accept, 0);
    step(); tx_push = 0;
    rd(2'd3, d); check("R7 overflow bit", d, 8'h20);
    wr(2'd3, 8'hFF);
    tx_free = 4'd3; tx_push = 1; #1 check("R7 accepted push", tx_accept, 1);
    step(); tx_push = 0; tx_free = 0;
    rd(2'd3, d); check("R7 no overflow", d, 8'h00);

    // R8 underflow
    rx_mem_data = 32'hDEADBEEF;
    rx_fill = 4'd2; rx_pop = 1; step(); rx_pop = 0;
    check("R8 popped word", rx_word, 32'hDEADBEEF);
    rx_fill = 0; rx_pop = 1; step(); rx_pop = 0;
    check("R8 empty pop word", rx_word, 0);
    rd(2'd3, d); check("R8 underflow bit", d, 8'h10);
    wr(2'd3, 8'hFF);

    // R9 events
    ev_pkt_done = 1; step(); ev_pkt_done = 0;
    rd(2'd3, d); check("R9 packet done", d, 8'h80);
    ev_all_done = 1; step(); ev_all_done = 0;
    rd(2'd3, d); check("R9 all done", d, 8'hC0);
    ev_nack = 1; ev_arb_lost = 1; step(); ev_nack = 0; ev_arb_lost = 0;
    rd(2'd3, d); check("R9 nack arb", d, 8'hCC);

    // R10 selective clear and set-wins
    wr(2'd3, 8'h84); rd(2'd3, d); check("R10 selective clear", d, 8'h48);
    ev_nack = 1; wr(2'd3, 8'h08); ev_nack = 0;
    rd(2'd3, d); check("R10 set wins", d, 8'h48);
    wr(2'd3, 8'hFF); rd(2'd3, d); check("R10 clear all", d, 8'h00);

    // R11 mask and irq
    ev_nack = 1; step(); ev_nack = 0;
    step(); check("R11 masked irq", irq, 0);
    wr(2'd2, 8'h08); rd(2'd2, d); check("R11 mask readback", d, 8'h08);
    check("R11 irq raised", irq, 1);
    wr(2'd3, 8'h08); step(); check("R11 irq dropped", irq, 0);
    ev_arb_lost = 1; step(); ev_arb_lost = 0;
    step(); check("R11 other source masked", irq, 0);
    wr(2'd3, 8'hFF); wr(2'd2, 8'h00);

    // R2 flush
    wr(2'd0, 8'h02);
    check("R2 tx flush req", {tx_flush_req, rx_flush_req}, 2'b10);
    repeat (3) step();
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R2 flush held", d, 8'h02);
    tx_flush_done = 1; step(); tx_flush_done = 0;
    rd(2'd0, d); check("R2 tx flush cleared", d, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R2 rx flush pending", d, 8'h01);
    rx_flush_done = 1; step(); rx_flush_done = 0;
    check("R2 rx flush cleared", {tx_flush_req, rx_flush_req}, 2'b00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule